// File: doc/BRIEF.md
# Timer/Counter with Double-Buffered Output Compare

This block is a parameterized up/down timer (8 bits by default) with one output compare channel. A single-cycle tick enable from an external prescaler advances it; a separate stop input indicates that no clock source is selected. A 2-bit waveform mode picks how each tick moves the counter:
- free-running wrap
- clear on compare match
- fast PWM
- phase-correct (up/down) PWM

A processor-side strobe interface writes the counter and the compare value and clears the flags. The counter and the active compare value are visible on read ports.

The compare value is held in two registers. In the two PWM modes a write lands in a shadow register, which is copied to the active register only when the counter leaves its maximum value. A write therefore never produces a shortened or asymmetric pulse. In the two non-PWM modes writes go straight to the active register. The waveform pin is driven from the compare match, the top and bottom of the count and the 2-bit output mode. A force strobe applies the compare action at once in the non-PWM modes.

Top module: `cmp_timer`

## Requirements
- R1: The counter moves only on a cycle where `tick` is 1 and `stopped` is 0, according to `wave_mode`:
  - 00 (free run) and 11 (fast PWM) increment and wrap from 0xFF to 0x00.
  - 10 (clear on match) loads 0x00 when the counter equals the active compare value, and otherwise increments.
  - 01 (phase correct) steps up from 0x00 to 0xFF, then down from 0xFF to 0x00, turning at each end.
- R2: When `tick` is 0 or `stopped` is 1, the counter holds its value, and `cnt_q` still shows it.
- R3: A `cnt_wr` strobe loads `cnt_wdata` into the counter one cycle later, overriding any count or clear in that cycle.
- R4: `ovf_flag` is set by a counting tick taken while the counter is 0xFF in modes 00, 10 and 11, and while the counter is 0x00 in mode 01. The `ovf_clr` strobe clears it, and a set in the same cycle wins over the clear.
- R5: `cmp_flag` is set by a counting tick taken while the counter equals the active compare value. The flag is cleared by the `cmp_clr` strobe or by the `cmp_ack` strobe; a set in the same cycle wins.
- R6: `cmp_irq` is 1 exactly when `cmp_flag` is 1 and `cmp_ie` is 1.
- R7: In modes 01 and 11, a `cmp_wr` strobe writes only the shadow register. The active value (`cmp_q`) takes the shadow value on a counting tick taken while the counter is 0xFF, and is otherwise unchanged.
- R8: In modes 00 and 10, a `cmp_wr` strobe updates `cmp_q` on the next cycle.
- R9: In modes 00 and 10, a match tick or a `force_cmp` strobe changes the pin state according to `out_mode`: 01 toggles, 10 drives low, 11 drives high.
- R10: In mode 11 with `out_mode` 10, the pin goes high at the wrap tick and low at a match tick. If both fall on the same tick, the wrap wins. `out_mode` 11 gives the inverse.
- R11: In mode 01 with `out_mode` 10, a match tick drives the pin low if that tick steps the counter up, and high if it steps the counter down. `out_mode` 11 gives the inverse. `force_cmp` has no effect in modes 01 and 11.
- R12: `wave_out` is 0 while `out_mode` is 00, and also while `out_mode` is 01 in a PWM mode. The internal pin state is kept, and it reappears when the pin is reconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled timer tick enable |
| stopped | input | 1 | No clock source selected; counter frozen |
| wave_mode | input | 2 | 00 free run, 01 phase-correct PWM, 10 clear on match, 11 fast PWM |
| out_mode | input | 2 | Pin behaviour on compare (see R9, R10, R11, R12) |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter write data |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write data |
| force_cmp | input | 1 | Force a compare action (non-PWM modes) |
| ovf_clr | input | 1 | Clear overflow flag |
| cmp_clr | input | 1 | Clear compare flag |
| cmp_ack | input | 1 | Compare interrupt acknowledge |
| cmp_ie | input | 1 | Compare interrupt enable |
| cnt_q | output | W | Counter value |
| cmp_q | output | W | Active compare value |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare match flag |
| cmp_irq | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform pin |

## Verification
Every register result is due on the first rising edge after the cycle that caused it: the counter, both flags, the active compare value and the pin state. `cmp_irq` and `wave_out` also follow `cmp_ie` and `out_mode` in the same cycle. The reference model therefore advances its state on each rising edge, from the inputs held since the previous falling edge. The outputs are compared a quarter period after each falling edge, once the stimulus for the new cycle has settled. Including the combinational gating in the expected value covers the same-cycle terms.

// File: rtl/ct_pkg.sv
// Shared encodings for the compare timer.
// Assumes the waveform-mode and output-mode codes listed in the brief.
package ct_pkg;
    typedef enum logic [1:0] {
        WM_FREE  = 2'b00,
        WM_PHASE = 2'b01,
        WM_CLEAR = 2'b10,
        WM_FAST  = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_LOW    = 2'b10,
        OM_HIGH   = 2'b11
    } omode_e;

    function automatic logic is_pwm(input wmode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction
endpackage

// File: rtl/ct_counter.sv
// Counter datapath: steps, clears or reverses on each counting tick.
// Holds the phase-correct direction and the overflow flag.
// Assumes step is already gated by the stop input.
module ct_counter
    import ct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  wmode_e       mode,
    input  logic [W-1:0] cmp_act,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         at_top,
    output logic         at_bottom,
    output logic         step_up,
    output logic         ovf_flag
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] MINV = '0;

    logic         dir_up;
    logic [W-1:0] cnt_nx;
    logic         ovf_evt;

    assign at_top    = (cnt == MAXV);
    assign at_bottom = (cnt == MINV);

    // Direction of the step a tick would take now (phase-correct mode).
    always_comb begin
        if (at_bottom)   step_up = 1'b1;
        else if (at_top) step_up = 1'b0;
        else             step_up = dir_up;
    end

    // Next count value for the selected waveform mode.
    always_comb begin
        unique case (mode)
            WM_PHASE: cnt_nx = step_up ? cnt + 1'b1 : cnt - 1'b1;
            WM_CLEAR: cnt_nx = (cnt == cmp_act) ? MINV : cnt + 1'b1;
            default:  cnt_nx = cnt + 1'b1;
        endcase
    end

    // Overflow point: bottom in phase-correct mode, the wrap otherwise.
    assign ovf_evt = step && ((mode == WM_PHASE) ? at_bottom : at_top);

    // Counter register; a processor write overrides the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= MINV;
        else if (wr)   cnt <= wdata;
        else if (step) cnt <= cnt_nx;
    end

    // Direction register, advanced only by phase-correct ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                               dir_up <= 1'b1;
        else if (step && !wr && mode == WM_PHASE) dir_up <= step_up;
    end

    // Overflow flag; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_evt) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end
endmodule

// File: rtl/ct_cmpreg.sv
// Compare value storage: a shadow register plus the active register.
// In PWM modes writes land in the shadow, which is copied on load.
// Otherwise writes go straight to the active register.
module ct_cmpreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm,
    input  logic         load,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act
);
    logic [W-1:0] shadow;

    // Shadow register always takes the last processor write.
    always_ff @(posedge clk) begin
        if (!rst_n)  shadow <= '0;
        else if (wr) shadow <= wdata;
    end

    // Active register: direct write outside PWM, aligned copy inside PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)              act <= '0;
        else if (wr && !pwm)     act <= wdata;
        else if (load && pwm)    act <= shadow;
    end
endmodule

// File: rtl/ct_outcmp.sv
// Compare flag and waveform pin state.
// Assumes match compares the counter with the active compare value,
// and that step_up gives the direction of the current phase-correct tick.
module ct_outcmp
    import ct_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step,
    input  logic   match,
    input  logic   at_top,
    input  logic   step_up,
    input  wmode_e mode,
    input  omode_e omode,
    input  logic   force_cmp,
    input  logic   flag_clr,
    output logic   cmp_flag,
    output logic   wave_q
);
    logic hit;
    logic wave_nx;

    assign hit = step && match;

    // Compare flag; a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        cmp_flag <= 1'b0;
        else if (hit)      cmp_flag <= 1'b1;
        else if (flag_clr) cmp_flag <= 1'b0;
    end

    // Next pin state from the mode, the output mode and the events.
    always_comb begin
        wave_nx = wave_q;
        unique case (mode)
            WM_FAST: begin
                if (omode[1]) begin
                    if (step && at_top) wave_nx = ~omode[0];
                    else if (hit)       wave_nx = omode[0];
                end
            end
            WM_PHASE: begin
                if (omode[1] && hit) wave_nx = step_up ? omode[0] : ~omode[0];
            end
            default: begin
                if (hit || force_cmp) begin
                    unique case (omode)
                        OM_TOGGLE: wave_nx = ~wave_q;
                        OM_LOW:    wave_nx = 1'b0;
                        OM_HIGH:   wave_nx = 1'b1;
                        default:   wave_nx = wave_q;
                    endcase
                end
            end
        endcase
    end

    // Pin state register.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_q <= 1'b0;
        else        wave_q <= wave_nx;
    end
endmodule

// File: rtl/cmp_timer.sv
// Top level of the compare timer: counter, compare storage, output unit.
// Assumes tick is a one-cycle enable from a prescaler in the clk domain.
module cmp_timer
    import ct_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         stopped,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   out_mode,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         force_cmp,
    input  logic         ovf_clr,
    input  logic         cmp_clr,
    input  logic         cmp_ack,
    input  logic         cmp_ie,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_q,
    output logic         ovf_flag,
    output logic         cmp_flag,
    output logic         cmp_irq,
    output logic         wave_out
);
    wmode_e mode;
    omode_e omode;
    logic   step;
    logic   pwm;
    logic   at_top;
    logic   at_bottom;
    logic   step_up;
    logic   match;
    logic   wave_q;
    logic   connected;

    assign mode  = wmode_e'(wave_mode);
    assign omode = omode_e'(out_mode);
    assign step  = tick && !stopped;
    assign pwm   = is_pwm(mode);
    assign match = (cnt_q == cmp_q);

    ct_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .mode      (mode),
        .cmp_act   (cmp_q),
        .wr        (cnt_wr),
        .wdata     (cnt_wdata),
        .ovf_clr   (ovf_clr),
        .cnt       (cnt_q),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .step_up   (step_up),
        .ovf_flag  (ovf_flag)
    );

    ct_cmpreg #(.W(W)) u_cmpreg (
        .clk   (clk),
        .rst_n (rst_n),
        .pwm   (pwm),
        .load  (step && at_top),
        .wr    (cmp_wr),
        .wdata (cmp_wdata),
        .act   (cmp_q)
    );

    ct_outcmp u_outcmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .match     (match),
        .at_top    (at_top),
        .step_up   (step_up),
        .mode      (mode),
        .omode     (omode),
        .force_cmp (force_cmp),
        .flag_clr  (cmp_clr || cmp_ack),
        .cmp_flag  (cmp_flag),
        .wave_q    (wave_q)
    );

    // Pin is connected unless output mode is off, or toggle in a PWM mode.
    assign connected = (omode != OM_OFF) && !(pwm && omode == OM_TOGGLE);
    assign wave_out  = connected && wave_q;
    assign cmp_irq   = cmp_flag && cmp_ie;
endmodule

// File: rtl/ct_sva.sv
// Property checker for cmp_timer, attached by bind below.
// Observes the top-level ports only.
module ct_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         stopped,
    input logic [1:0]   wave_mode,
    input logic [1:0]   out_mode,
    input logic         cnt_wr,
    input logic [W-1:0] cnt_wdata,
    input logic         cmp_wr,
    input logic [W-1:0] cmp_wdata,
    input logic         cmp_ack,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cmp_q,
    input logic         ovf_flag,
    input logic         cmp_flag,
    input logic         wave_out
);
    localparam logic [W-1:0] MAXV = '1;

    logic step_s;
    logic pwm_s;
    assign step_s = tick && !stopped;
    assign pwm_s  = wave_mode[0];

    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !step_s) |=> $stable(cnt_q));

    p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));

    p_ovf_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_s && cnt_q == MAXV && wave_mode != 2'b01) |=> ovf_flag);

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ack && !(step_s && cnt_q == cmp_q)) |=> !cmp_flag);

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_s && !(step_s && cnt_q == MAXV)) |=> $stable(cmp_q));

    p_direct_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !pwm_s) |=> (cmp_q == $past(cmp_wdata)));

    p_pin_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'b00) |-> !wave_out);
endmodule

bind cmp_timer ct_sva #(.W(W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .stopped   (stopped),
    .wave_mode (wave_mode),
    .out_mode  (out_mode),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .cmp_ack   (cmp_ack),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag),
    .wave_out  (wave_out)
);

// File: tb/tb_cmp_timer.sv
// Bench for cmp_timer: behavioural reference model compared every cycle.
module tb_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       stopped = 1'b0;
    logic [1:0] wave_mode = 2'b00;
    logic [1:0] out_mode = 2'b00;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'h00;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic       force_cmp = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       cmp_clr = 1'b0;
    logic       cmp_ack = 1'b0;
    logic       cmp_ie = 1'b0;
    logic [7:0] cnt_q;
    logic [7:0] cmp_q;
    logic       ovf_flag;
    logic       cmp_flag;
    logic       cmp_irq;
    logic       wave_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer #(.W(8)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stopped(stopped),
        .wave_mode(wave_mode), .out_mode(out_mode),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .force_cmp(force_cmp), .ovf_clr(ovf_clr), .cmp_clr(cmp_clr),
        .cmp_ack(cmp_ack), .cmp_ie(cmp_ie),
        .cnt_q(cnt_q), .cmp_q(cmp_q), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .cmp_irq(cmp_irq), .wave_out(wave_out)
    );

    // Reference model state
    logic [7:0] m_cnt, m_act, m_buf;
    logic       m_up, m_ovf, m_cf, m_wave;
    string      cnt_tag = "R1";
    string      cmp_tag = "R8";
    logic       s, hit, pwm, du;
    logic [7:0] nc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 8'h00; m_act = 8'h00; m_buf = 8'h00;
            m_up = 1'b1; m_ovf = 1'b0; m_cf = 1'b0; m_wave = 1'b0;
        end else begin
            s   = tick && !stopped;
            hit = (m_cnt == m_act);
            pwm = (wave_mode == 2'b01) || (wave_mode == 2'b11);
            // direction of this step in up/down counting
            if (m_cnt == 8'h00)      du = 1'b1;
            else if (m_cnt == 8'hFF) du = 1'b0;
            else                     du = m_up;
            nc = m_cnt;
            if (s) begin
                if (wave_mode == 2'b01)      nc = du ? m_cnt + 8'd1 : m_cnt - 8'd1;
                else if (wave_mode == 2'b10) nc = hit ? 8'h00 : m_cnt + 8'd1;
                else                         nc = m_cnt + 8'd1;
            end
            // wave pin state
            if (!pwm) begin
                if ((s && hit) || force_cmp) begin
                    if (out_mode == 2'b01)      m_wave = ~m_wave;
                    else if (out_mode == 2'b10) m_wave = 1'b0;
                    else if (out_mode == 2'b11) m_wave = 1'b1;
                end
            end else if (wave_mode == 2'b11 && out_mode[1]) begin
                if (s && m_cnt == 8'hFF) m_wave = (out_mode == 2'b10);
                else if (s && hit)       m_wave = (out_mode == 2'b11);
            end else if (wave_mode == 2'b01 && out_mode[1] && s && hit) begin
                m_wave = du ? (out_mode == 2'b11) : (out_mode == 2'b10);
            end
            // flags
            if (s && ((wave_mode == 2'b01) ? (m_cnt == 8'h00) : (m_cnt == 8'hFF))) m_ovf = 1'b1;
            else if (ovf_clr) m_ovf = 1'b0;
            if (s && hit) m_cf = 1'b1;
            else if (cmp_clr || cmp_ack) m_cf = 1'b0;
            // compare storage
            if (cmp_wr && !pwm) m_act = cmp_wdata;
            else if (s && pwm && m_cnt == 8'hFF) m_act = m_buf;
            if (cmp_wr) m_buf = cmp_wdata;
            cmp_tag = pwm ? "R7" : "R8";
            // counter
            if (cnt_wr) begin
                m_cnt = cnt_wdata; cnt_tag = "R3";
            end else begin
                if (s && wave_mode == 2'b01) m_up = du;
                m_cnt = nc; cnt_tag = s ? "R1" : "R2";
            end
        end
    end

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %02h expected %02h", tag, what, $time, act, exp);
        end
    endtask

    // Compare a quarter period after each falling edge.
    always @(negedge clk) begin
        logic conn, pw;
        string wtag;
        #(CLK_PERIOD/4);
        if (!done) begin
            pw   = (wave_mode == 2'b01) || (wave_mode == 2'b11);
            conn = (out_mode != 2'b00) && !(pw && out_mode == 2'b01);
            if (!conn)                   wtag = "R12";
            else if (wave_mode == 2'b11) wtag = "R10";
            else if (wave_mode == 2'b01) wtag = "R11";
            else                         wtag = "R9";
            chk(cnt_tag, "cnt_q", cnt_q, m_cnt);
            chk(cmp_tag, "cmp_q", cmp_q, m_act);
            chk("R4", "ovf_flag", {7'd0, ovf_flag}, {7'd0, m_ovf});
            chk("R5", "cmp_flag", {7'd0, cmp_flag}, {7'd0, m_cf});
            chk("R6", "cmp_irq", {7'd0, cmp_irq}, {7'd0, m_cf & cmp_ie});
            chk(wtag, "wave_out", {7'd0, wave_out}, {7'd0, conn & m_wave});
        end
    end

    task automatic run(int n, int per);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = ((i % per) == 0);
        end
    endtask

    task automatic write_cnt(logic [7:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic write_cmp(logic [7:0] v);
        @(negedge clk); cmp_wr = 1'b1; cmp_wdata = v;
        @(negedge clk); cmp_wr = 1'b0;
    endtask

    task automatic strobe_force();
        @(negedge clk); force_cmp = 1'b1;
        @(negedge clk); force_cmp = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        // reset state
        run(4, 1);
        @(negedge clk); rst_n = 1'b1; tick = 1'b0;
        run(2, 1000);
        // R1 R9 free-running count with toggle on match
        write_cmp(8'h40);
        out_mode = 2'b01;
        run(600, 1);
        // R4 R5 flag clears
        @(negedge clk); ovf_clr = 1'b1; cmp_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0; cmp_clr = 1'b0;
        run(5, 1000);
        // R2 stopped with ticks, write while stopped
        stopped = 1'b1;
        run(20, 1);
        write_cnt(8'h77);
        run(5, 1);
        stopped = 1'b0;
        // R3 write during ticking
        tick = 1'b1;
        write_cnt(8'hF0);
        run(30, 1);
        // sparse ticks
        run(300, 3);
        // R8 R9 clear-on-match mode, force strobes
        wave_mode = 2'b10; out_mode = 2'b10;
        write_cmp(8'h10);
        run(60, 1);
        out_mode = 2'b11;
        run(60, 1);
        tick = 1'b0;
        out_mode = 2'b10; strobe_force();
        out_mode = 2'b01; strobe_force();
        out_mode = 2'b00; strobe_force();
        run(3, 1000);
        out_mode = 2'b01; run(3, 1000);
        // R6 interrupt enable and acknowledge
        cmp_ie = 1'b1;
        run(40, 1);
        @(negedge clk); cmp_ack = 1'b1;
        @(negedge clk); cmp_ack = 1'b0;
        run(5, 1000);
        cmp_ie = 1'b0;
        run(20, 1);
        cmp_ie = 1'b1;
        // R7 R10 fast PWM with buffered compare
        wave_mode = 2'b11; out_mode = 2'b10;
        write_cmp(8'h80);
        run(300, 1);
        write_cmp(8'h20);
        run(300, 1);
        out_mode = 2'b11; run(300, 1);
        out_mode = 2'b01; strobe_force(); run(50, 1);
        out_mode = 2'b10;
        write_cmp(8'hFF);
        run(600, 1);
        // R11 phase-correct PWM
        wave_mode = 2'b01; out_mode = 2'b10;
        write_cmp(8'h30);
        run(1100, 1);
        out_mode = 2'b11;
        write_cmp(8'hC0);
        run(700, 1);
        strobe_force();
        run(300, 2);
        // R12 disconnect and reconnect in PWM
        out_mode = 2'b00; run(200, 1);
        out_mode = 2'b10; run(200, 1);
        finish_run();
    end
endmodule